// File: doc/BRIEF.md
# Dual Byte FIFO with Threshold Flags and Self-Clearing Flush

This block holds the bytes that travel between a register interface and a serial bus engine. It has two independent byte queues. The transmit queue is written by software and drained by the engine. The receive queue is filled by the engine and drained by software. Each queue keeps a live fill level. The level is compared against a 4-bit programmable threshold, and the result feeds the interrupt logic. The other status outputs are an empty flag and a full flag per queue, plus a one-cycle pulse when software writes into a transmit queue that is already full.

Each queue can be emptied by a flush request. A flush is not instant. After the request, a busy indication stays high for a fixed number of cycles, and software polls it. When the busy indication drops, the queue is empty. While a flush runs, the queue takes no pushes and no pops. Data leaves each queue in show-ahead form: the head byte is always visible, and a pop moves on to the next byte.

Top module: `i2c_fifo_pair`

## Requirements
- R1: Each queue stores up to 16 single-byte entries and returns them in the order they were pushed. The level output gives the number of stored entries, from 0 to 16, and it is updated on the clock edge that accepts a push or a pop.
- R2: The empty flag is 1 exactly when the level is 0. The full flag is 1 exactly when the level is 16.
- R3: The transmit low flag is 1 while the transmit level is less than or equal to the 4-bit transmit threshold (0 to 15).
- R4: The receive high flag is 1 while the receive level is greater than or equal to the 4-bit receive threshold (0 to 15).
- R5: A transmit push while the transmit queue is full is discarded. Level and contents stay unchanged, and `tx_overrun` is 1 for exactly the one cycle after the clock edge of that push. A pop in the same cycle is still performed.
- R6: A flush request that arrives while no flush is running makes the queue's busy output read 1 for exactly 4 cycles after the requesting edge. When busy returns to 0, the level is 0.
- R7: Pushes and pops are ignored while busy is 1, and also in the cycle that carries the flush request.
- R8: When a queue is empty, its read data output is 0. A pop of an empty queue leaves the level at 0.
- R9: A push and a pop in the same cycle on a queue that is neither empty nor full leave the level unchanged and keep the order.
- R10: After reset, both levels are 0, both queues are empty, no flush is busy and `tx_overrun` is 0.
- R11: A receive push while the receive queue is full is discarded, with no flag raised.
- R12: A flush request made while that queue's flush is already running neither restarts nor extends it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_push | input | 1 | Software writes one byte into the transmit queue |
| tx_wdata | input | 8 | Byte written into the transmit queue |
| tx_pop | input | 1 | Engine takes the transmit head byte |
| tx_rdata | output | 8 | Transmit head byte, 0 when empty |
| rx_push | input | 1 | Engine stores one received byte |
| rx_wdata | input | 8 | Received byte |
| rx_pop | input | 1 | Software takes the receive head byte |
| rx_rdata | output | 8 | Receive head byte, 0 when empty |
| tx_thresh | input | 4 | Transmit low-water threshold |
| rx_thresh | input | 4 | Receive high-water threshold |
| tx_flush_req | input | 1 | Request a transmit flush |
| rx_flush_req | input | 1 | Request a receive flush |
| tx_flush_busy | output | 1 | Transmit flush in progress |
| rx_flush_busy | output | 1 | Receive flush in progress |
| tx_level | output | 5 | Transmit fill level |
| rx_level | output | 5 | Receive fill level |
| tx_empty | output | 1 | Transmit queue empty |
| tx_low | output | 1 | Transmit level at or below threshold |
| tx_full | output | 1 | Transmit queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_high | output | 1 | Receive level at or above threshold |
| rx_full | output | 1 | Receive queue full |
| tx_overrun | output | 1 | Pulse after a push into a full transmit queue |

## Verification
The cases of interest are those where two of the block's actions fall in the same cycle. A flush request can arrive in the same cycle as a push or a pop, and a push into a full transmit queue can arrive in the same cycle as an engine pop. The bench drives both pairs on purpose in directed steps. Its random phase also lets them collide freely. A bench model applies the stated precedence: the flush blocks the data move, while the pop still happens and the overrunning byte is still dropped. Every output is compared against that model in each cycle.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;
    localparam int unsigned DEF_DATA_W    = 8;
    localparam int unsigned DEF_DEPTH     = 16;
    localparam int unsigned DEF_THR_W     = 4;
    localparam int unsigned DEF_FLUSH_CYC = 4;

    typedef enum logic {
        CMP_AT_MOST  = 1'b0,
        CMP_AT_LEAST = 1'b1
    } cmp_mode_e;
endpackage

// File: rtl/fifo_thresh_cmp.sv
module fifo_thresh_cmp
    import fifo_pair_pkg::*;
#(
    parameter int unsigned LVL_W = 5,
    parameter int unsigned THR_W = 4,
    parameter cmp_mode_e   MODE  = CMP_AT_MOST
) (
    input  logic [LVL_W-1:0] level,
    input  logic [THR_W-1:0] thresh,
    output logic             hit
);
    localparam int unsigned CW = (LVL_W > THR_W) ? LVL_W : THR_W;

    logic [CW-1:0] lvl_x;
    logic [CW-1:0] thr_x;

    assign lvl_x = CW'(level);
    assign thr_x = CW'(thresh);

    generate
        if (MODE == CMP_AT_LEAST) begin : g_at_least
            assign hit = (lvl_x >= thr_x);
        end else begin : g_at_most
            assign hit = (lvl_x <= thr_x);
        end
    endgenerate
endmodule

// File: rtl/fifo_flush_seq.sv
module fifo_flush_seq #(
    parameter int unsigned CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            if (s_q.cnt == LAST) begin
                s_d.busy = 1'b0;
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else if (start) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign done = s_q.busy && (s_q.cnt == LAST);

    // R6: the last counted cycle always ends the flush
    p_busy_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R12: a request during a running flush does not reset the count
    p_no_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> (busy && s_q.cnt == CW'($past(s_q.cnt) + 1'b1)));
endmodule

// File: rtl/fifo_byte_lane.sv
module fifo_byte_lane
    import fifo_pair_pkg::*;
#(
    parameter int unsigned DW        = DEF_DATA_W,
    parameter int unsigned DEPTH     = DEF_DEPTH,
    parameter int unsigned THR_W     = DEF_THR_W,
    parameter int unsigned FLUSH_CYC = DEF_FLUSH_CYC,
    parameter cmp_mode_e   MODE      = CMP_AT_MOST
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [DW-1:0]              wdata,
    input  logic                       pop,
    input  logic                       flush_req,
    input  logic [THR_W-1:0]           thresh,
    output logic [DW-1:0]              rdata,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       empty,
    output logic                       full,
    output logic                       thr_hit,
    output logic                       flush_busy
);
    localparam int unsigned LVL_W = $clog2(DEPTH + 1);
    localparam int unsigned AW    = $clog2(DEPTH);
    localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);
    localparam logic [AW-1:0]    PTR_LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            rd;
        logic [AW-1:0]            wr;
        logic [LVL_W-1:0]         lvl;
    } lane_t;

    lane_t s_d, s_q;
    logic  flush_done;
    logic  blocked;
    logic  push_ok;
    logic  pop_ok;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    fifo_flush_seq #(.CYCLES(FLUSH_CYC)) u_flush (
        .clk   (clk),
        .rst_n (rst_n),
        .start (flush_req),
        .busy  (flush_busy),
        .done  (flush_done)
    );

    assign blocked = flush_busy | flush_req;
    assign push_ok = push & ~blocked & (s_q.lvl != LVL_FULL);
    assign pop_ok  = pop & ~blocked & (s_q.lvl != '0);

    always_comb begin
        s_d = s_q;
        if (push_ok) begin
            s_d.mem[s_q.wr] = wdata;
            s_d.wr          = ptr_next(s_q.wr);
        end
        if (pop_ok) begin
            s_d.rd = ptr_next(s_q.rd);
        end
        case ({push_ok, pop_ok})
            2'b10:   s_d.lvl = s_q.lvl + 1'b1;
            2'b01:   s_d.lvl = s_q.lvl - 1'b1;
            default: s_d.lvl = s_q.lvl;
        endcase
        if (flush_done) begin
            s_d.rd  = '0;
            s_d.wr  = '0;
            s_d.lvl = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    fifo_thresh_cmp #(.LVL_W(LVL_W), .THR_W(THR_W), .MODE(MODE)) u_cmp (
        .level  (s_q.lvl),
        .thresh (thresh),
        .hit    (thr_hit)
    );

    assign level = s_q.lvl;
    assign empty = (s_q.lvl == '0);
    assign full  = (s_q.lvl == LVL_FULL);
    assign rdata = (s_q.lvl == '0) ? '0 : s_q.mem[s_q.rd];

    // R1: level never exceeds the depth
    p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_FULL);

    // R5 / R11: a push into a full queue without a pop keeps the level
    p_full_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && full && !blocked) |=> $stable(level));

    // R6: when the flush ends, the queue is empty
    p_flush_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flush_busy) |-> (level == '0));

    // R7: level frozen while a flush runs, except at its end
    p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_busy && !flush_done) |=> $stable(level));

    // R8: popping an empty queue leaves it empty and reading 0
    p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty && !blocked) |=> (empty && rdata == '0));
endmodule

// File: rtl/i2c_fifo_pair.sv
module i2c_fifo_pair
    import fifo_pair_pkg::*;
#(
    parameter int unsigned DW        = DEF_DATA_W,
    parameter int unsigned DEPTH     = DEF_DEPTH,
    parameter int unsigned THR_W     = DEF_THR_W,
    parameter int unsigned FLUSH_CYC = DEF_FLUSH_CYC
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tx_push,
    input  logic [DW-1:0]              tx_wdata,
    input  logic                       tx_pop,
    output logic [DW-1:0]              tx_rdata,
    input  logic                       rx_push,
    input  logic [DW-1:0]              rx_wdata,
    input  logic                       rx_pop,
    output logic [DW-1:0]              rx_rdata,
    input  logic [THR_W-1:0]           tx_thresh,
    input  logic [THR_W-1:0]           rx_thresh,
    input  logic                       tx_flush_req,
    input  logic                       rx_flush_req,
    output logic                       tx_flush_busy,
    output logic                       rx_flush_busy,
    output logic [$clog2(DEPTH+1)-1:0] tx_level,
    output logic [$clog2(DEPTH+1)-1:0] rx_level,
    output logic                       tx_empty,
    output logic                       tx_low,
    output logic                       tx_full,
    output logic                       rx_empty,
    output logic                       rx_high,
    output logic                       rx_full,
    output logic                       tx_overrun
);
    logic ovr_d, ovr_q;

    fifo_byte_lane #(
        .DW(DW), .DEPTH(DEPTH), .THR_W(THR_W),
        .FLUSH_CYC(FLUSH_CYC), .MODE(CMP_AT_MOST)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (tx_push),
        .wdata      (tx_wdata),
        .pop        (tx_pop),
        .flush_req  (tx_flush_req),
        .thresh     (tx_thresh),
        .rdata      (tx_rdata),
        .level      (tx_level),
        .empty      (tx_empty),
        .full       (tx_full),
        .thr_hit    (tx_low),
        .flush_busy (tx_flush_busy)
    );

    fifo_byte_lane #(
        .DW(DW), .DEPTH(DEPTH), .THR_W(THR_W),
        .FLUSH_CYC(FLUSH_CYC), .MODE(CMP_AT_LEAST)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (rx_push),
        .wdata      (rx_wdata),
        .pop        (rx_pop),
        .flush_req  (rx_flush_req),
        .thresh     (rx_thresh),
        .rdata      (rx_rdata),
        .level      (rx_level),
        .empty      (rx_empty),
        .full       (rx_full),
        .thr_hit    (rx_high),
        .flush_busy (rx_flush_busy)
    );

    always_comb begin
        ovr_d = tx_push & tx_full & ~tx_flush_busy & ~tx_flush_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ovr_q <= 1'b0;
        else        ovr_q <= ovr_d;
    end

    assign tx_overrun = ovr_q;

    // R5: a write into a full transmit queue raises the overrun pulse
    p_overrun_seen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && tx_full && !tx_flush_busy && !tx_flush_req) |=> tx_overrun);

    // R5: the pulse never follows a cycle where the queue was not full
    p_overrun_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_full |=> !tx_overrun);
endmodule

// File: tb/i2c_fifo_pair_bench.sv
`timescale 1ns/1ps
module i2c_fifo_pair_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       tx_push, tx_pop, rx_push, rx_pop, tx_flush_req, rx_flush_req;
    logic [7:0] tx_wdata, rx_wdata, tx_rdata, rx_rdata;
    logic [3:0] tx_thresh, rx_thresh;
    logic       tx_flush_busy, rx_flush_busy;
    logic [4:0] tx_level, rx_level;
    logic       tx_empty, tx_low, tx_full, rx_empty, rx_high, rx_full, tx_overrun;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    // model state, index 0 = transmit, 1 = receive
    logic [7:0] mq [2][16];
    int         mh [2];
    int         mc [2];
    int         mrem [2];
    bit         mbusy [2];
    bit         movr;

    always #2 clk = ~clk;

    i2c_fifo_pair u_i2c_fifo_pair (
        .clk(clk), .rst_n(rst_n),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
        .tx_flush_req(tx_flush_req), .rx_flush_req(rx_flush_req),
        .tx_flush_busy(tx_flush_busy), .rx_flush_busy(rx_flush_busy),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_empty(tx_empty), .tx_low(tx_low), .tx_full(tx_full),
        .rx_empty(rx_empty), .rx_high(rx_high), .rx_full(rx_full),
        .tx_overrun(tx_overrun)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    function automatic int head_of(input int l);
        return (mc[l] == 0) ? 0 : int'(mq[l][mh[l]]);
    endfunction

    function automatic bit flush_blocks(input int l, input bit f);
        return mbusy[l] | f;
    endfunction

    task automatic model_lane(input int l, input bit p, input logic [7:0] d,
                              input bit q, input bit f);
        int  h0, c0;
        bit  blk, pok, qok;
        h0  = mh[l];
        c0  = mc[l];
        blk = flush_blocks(l, f);
        pok = p && !blk && (c0 < 16);
        qok = q && !blk && (c0 > 0);
        if (l == 0) movr = p && !blk && (c0 == 16);
        if (pok) mq[l][(h0 + c0) % 16] = d;
        if (qok) mh[l] = (h0 + 1) % 16;
        mc[l] = c0 + int'(pok) - int'(qok);
        if (mbusy[l]) begin
            mrem[l]--;
            if (mrem[l] == 0) begin
                mbusy[l] = 1'b0;
                mc[l]    = 0;
                mh[l]    = 0;
            end
        end else if (f) begin
            mbusy[l] = 1'b1;
            mrem[l]  = 4;
        end
    endtask

    task automatic check_all(input string tag);
        chk("R1", {"tx_level ", tag}, int'(tx_level), mc[0]);
        chk("R1", {"rx_level ", tag}, int'(rx_level), mc[1]);
        chk("R1", {"tx_rdata ", tag}, int'(tx_rdata), head_of(0));
        chk("R1", {"rx_rdata ", tag}, int'(rx_rdata), head_of(1));
        chk("R2", {"tx_empty ", tag}, int'(tx_empty), int'(mc[0] == 0));
        chk("R2", {"tx_full ", tag},  int'(tx_full),  int'(mc[0] == 16));
        chk("R2", {"rx_empty ", tag}, int'(rx_empty), int'(mc[1] == 0));
        chk("R2", {"rx_full ", tag},  int'(rx_full),  int'(mc[1] == 16));
        chk("R3", {"tx_low ", tag},   int'(tx_low),   int'(mc[0] <= int'(tx_thresh)));
        chk("R4", {"rx_high ", tag},  int'(rx_high),  int'(mc[1] >= int'(rx_thresh)));
        chk("R5", {"tx_overrun ", tag}, int'(tx_overrun), int'(movr));
        chk("R6", {"tx_flush_busy ", tag}, int'(tx_flush_busy), int'(mbusy[0]));
        chk("R6", {"rx_flush_busy ", tag}, int'(rx_flush_busy), int'(mbusy[1]));
    endtask

    // one clock: drive at the falling edge, step the model, check at the next falling edge
    task automatic cyc(input bit tp, input logic [7:0] td, input bit tq,
                       input bit rp, input logic [7:0] rd, input bit rq,
                       input bit tf, input bit rf, input string tag);
        tx_push = tp; tx_wdata = td; tx_pop = tq;
        rx_push = rp; rx_wdata = rd; rx_pop = rq;
        tx_flush_req = tf; rx_flush_req = rf;
        model_lane(0, tp, td, tq, tf);
        model_lane(1, rp, rd, rq, rf);
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic idle(input string tag);
        cyc(0, 8'h00, 0, 0, 8'h00, 0, 0, 0, tag);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not end, actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        for (int l = 0; l < 2; l++) begin
            mh[l] = 0; mc[l] = 0; mrem[l] = 0; mbusy[l] = 1'b0;
        end
        movr = 1'b0;
        rst_n = 1'b0;
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
        tx_flush_req = 0; rx_flush_req = 0;
        tx_wdata = 8'h00; rx_wdata = 8'h00;
        tx_thresh = 4'd3; rx_thresh = 4'd8;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset values
        chk("R10", "tx_level after reset", int'(tx_level), 0);
        chk("R10", "rx_level after reset", int'(rx_level), 0);
        chk("R10", "tx_empty after reset", int'(tx_empty), 1);
        chk("R10", "rx_empty after reset", int'(rx_empty), 1);
        chk("R10", "busy after reset", int'(tx_flush_busy | rx_flush_busy), 0);
        chk("R10", "tx_overrun after reset", int'(tx_overrun), 0);

        // R1/R3: fill the transmit queue
        for (int i = 0; i < 16; i++) cyc(1, 8'(i * 7 + 1), 0, 0, 8'h00, 0, 0, 0, "R1 fill");
        // R5: write into full queue
        cyc(1, 8'hEE, 0, 0, 8'h00, 0, 0, 0, "R5 overrun");
        chk("R5", "tx_overrun after full write", int'(tx_overrun), 1);
        chk("R5", "tx_level after dropped write", int'(tx_level), 16);
        idle("R5 pulse ends");
        chk("R5", "tx_overrun one cycle only", int'(tx_overrun), 0);
        // R5: full write with pop in the same cycle
        cyc(1, 8'hDD, 1, 0, 8'h00, 0, 0, 0, "R5 drop with pop");
        chk("R5", "tx_level after drop with pop", int'(tx_level), 15);
        // R1: drain in order
        for (int i = 0; i < 15; i++) cyc(0, 8'h00, 1, 0, 8'h00, 0, 0, 0, "R1 drain");
        chk("R8", "tx_rdata when empty", int'(tx_rdata), 0);

        // R8: pop of empty receive queue
        cyc(0, 8'h00, 0, 0, 8'h00, 1, 0, 0, "R8 empty pop");
        chk("R8", "rx_level after empty pop", int'(rx_level), 0);
        chk("R8", "rx_rdata after empty pop", int'(rx_rdata), 0);

        // R9: simultaneous push and pop
        for (int i = 0; i < 3; i++) cyc(0, 8'h00, 0, 1, 8'(8'h40 + i), 0, 0, 0, "R9 load");
        for (int i = 0; i < 4; i++) cyc(0, 8'h00, 0, 1, 8'(8'h80 + i), 1, 0, 0, "R9 push+pop");
        chk("R9", "rx_level after push+pop", int'(rx_level), 3);

        // R3/R4: threshold extremes
        tx_thresh = 4'd0; rx_thresh = 4'd0;
        idle("R3 R4 thr 0");
        chk("R4", "rx_high with thresh 0", int'(rx_high), 1);
        tx_thresh = 4'd15; rx_thresh = 4'd15;
        for (int i = 0; i < 13; i++) cyc(1, 8'(i), 0, 1, 8'(i), 0, 0, 0, "R3 R4 thr 15");
        chk("R4", "rx_high at level 16 thresh 15", int'(rx_high), 1);
        chk("R3", "tx_low at level 13 thresh 15", int'(tx_low), 1);
        // R11: receive push into full queue
        cyc(0, 8'h00, 0, 1, 8'h99, 0, 0, 0, "R11 rx full push");
        chk("R11", "rx_level after full push", int'(rx_level), 16);
        chk("R11", "tx_overrun not raised by rx", int'(tx_overrun), 0);

        // R6/R7: flush with a push in the same cycle, then traffic while busy
        cyc(1, 8'h11, 1, 1, 8'h22, 1, 1, 1, "R7 flush+push");
        chk("R7", "tx_level unchanged in request cycle", int'(tx_level), 13);
        chk("R6", "tx_flush_busy after request", int'(tx_flush_busy), 1);
        cyc(1, 8'h11, 1, 1, 8'h22, 1, 0, 1, "R12 re-request");
        cyc(1, 8'h33, 1, 0, 8'h00, 1, 1, 0, "R7 busy traffic");
        cyc(0, 8'h00, 1, 1, 8'h44, 0, 0, 0, "R7 busy traffic");
        chk("R7", "rx_level frozen while busy", int'(rx_level), 16);
        idle("R6 flush end");
        chk("R6", "tx_level after flush", int'(tx_level), 0);
        chk("R12", "rx_flush_busy not extended", int'(rx_flush_busy), 0);
        chk("R6", "rx_empty after flush", int'(rx_empty), 1);

        // random phase
        tx_thresh = 4'd1; rx_thresh = 4'd8;
        for (int n = 0; n < 4000; n++) begin
            bit tp, tq, rp, rq, tf, rf;
            tp = ($urandom % 100) < 55;
            tq = ($urandom % 100) < 40;
            rp = ($urandom % 100) < 50;
            rq = ($urandom % 100) < 45;
            tf = ($urandom % 100) < 2;
            rf = ($urandom % 100) < 2;
            if (($urandom % 100) == 0) begin
                tx_thresh = 4'($urandom % 16);
                rx_thresh = 4'($urandom % 16);
            end
            cyc(tp, 8'($urandom), tq, rp, 8'($urandom), rq, tf, rf, "random");
        end

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule